// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings a fast-page-mode dynamic RAM from power-on to a usable state and then keeps its contents alive. Once reset is released it holds all strobes inactive for a programmable settle time. It then runs a fixed number of wake-up cycles, each of which carries a RAS pulse. When the wake-up cycles are complete, it tells the access controller that the memory is ready and gives the bus to it.

From that point on, an interval timer raises a refresh request once per refresh slot. The slot is sized so that every row is refreshed once per retention period. At the default 100 MHz clock this is one slot per 1560 clocks, which gives 512 refreshes per 8 ms. The access controller answers the request with a grant. The sequencer then takes the bus and performs one CAS-before-RAS refresh cycle with both byte CAS strobes. It keeps CAS setup, CAS hold, minimum RAS low time and RAS precharge in whole clocks, and then releases the bus. The device's internal row counter supplies the row, so no address is driven.

If a request waits longer than the deadline without a grant, the memory is declared not ready. The next grant then runs the full wake-up burst again instead of a single refresh. All lengths are parameters given in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, `ras_n_o`, `lcas_n_o` and `ucas_n_o` are 1, `bus_own_o` is 1, and `mem_ready_o` and `ref_req_o` are 0.
- R2: After reset is released, all strobes stay high for exactly PAUSE_CYC clocks. CAS first goes low in clock PAUSE_CYC.
- R3: After the pause, exactly WAKE_CNT refresh cycles run back to back. `mem_ready_o` rises one clock after the last precharge ends, which is clock PAUSE_CYC + WAKE_CNT*(T_CSR+T_RAS+T_RP) + 1.
- R4: Every refresh cycle has the same shape. CAS is low for T_CSR clocks before RAS falls. CAS stays low for T_CHR clocks after RAS falls. RAS is low for T_RAS clocks. CAS returns high only while RAS is still low.
- R5: Between consecutive RAS pulses, RAS and both CAS strobes are high together for at least T_RP clocks.
- R6: After `mem_ready_o` first rises, `ref_req_o` rises exactly REF_INTERVAL clocks later.
- R7: `ref_req_o` stays high without any strobe activity until a grant arrives. A grant sampled while the request is high sets `bus_own_o` to 1 and `ref_req_o` to 0 on the next clock. Exactly one refresh cycle follows, and after it `bus_own_o` returns to 0 with `mem_ready_o` held at 1.
- R8: RAS or CAS is low only while `bus_own_o` is 1, and `ref_req_o` is high only while `bus_own_o` is 0.
- R9: If a request waits DEADLINE_CYC clocks without a grant, `mem_ready_o` falls on exactly that clock. The next grant runs WAKE_CNT refresh cycles, after which `mem_ready_o` returns to 1.
- R10: `lcas_n_o` and `ucas_n_o` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt_i | input | 1 | Grant from the access controller |
| ref_req_o | output | 1 | Refresh request to the access controller |
| bus_own_o | output | 1 | High while the sequencer drives the DRAM strobes |
| mem_ready_o | output | 1 | Memory initialised and refresh deadline met |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Low-byte column strobe, active low |
| ucas_n_o | output | 1 | High-byte column strobe, active low |

## Verification
The hardest case to reach is the missed deadline and the recovery that follows it. It occurs only when the access controller refuses the bus for longer than the deadline. Even then it shows at the ports only indirectly: `mem_ready_o` drops, and a later grant produces a whole wake-up burst instead of a single pulse. The stimulus first completes several normal grant cycles. It then withholds the grant past the deadline while the interval timer keeps ticking, measures the exact clock on which ready falls, and grants. The scoreboard then expects exactly WAKE_CNT correctly shaped pulses before ready returns.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [1:0] {
        ST_PAUSE,
        ST_WAKE,
        ST_RUN,
        ST_REF
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HOLD,
        PH_LOW,
        PH_PRE
    } cbr_phase_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CYCLES = 20000
) (
    input  logic clk,
    input  logic rst,
    output logic expired_o
);
    localparam int W = dram_seq_pkg::cnt_w(CYCLES);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cbr_engine.sv
module cbr_engine
    import dram_seq_pkg::*;
#(
    parameter int T_CSR   = 1,
    parameter int T_CHR   = 1,
    parameter int T_RAS   = 6,
    parameter int T_RP    = 4,
    parameter int MAX_BURST = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start_i,
    input  logic [cnt_w(MAX_BURST)-1:0]        burst_i,
    output strobe_t                            strobe_o,
    output logic                               busy_o,
    output logic                               done_o
);
    localparam int NW   = cnt_w(MAX_BURST);
    localparam int TW   = cnt_w(max3(T_CSR, T_RAS, T_RP));
    localparam int LOWR = T_RAS - T_CHR;

    cbr_phase_t     phase_q;
    logic [TW-1:0]  cnt_q;
    logic [NW-1:0]  left_q;
    logic           done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start_i) begin
                    phase_q <= PH_SETUP;
                    cnt_q   <= TW'(T_CSR - 1);
                    left_q  <= (burst_i == '0) ? '0 : burst_i - 1'b1;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                case (phase_q)
                    PH_SETUP: begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= TW'(T_CHR - 1);
                    end
                    PH_HOLD: begin
                        phase_q <= PH_LOW;
                        cnt_q   <= TW'(LOWR - 1);
                    end
                    PH_LOW: begin
                        phase_q <= PH_PRE;
                        cnt_q   <= TW'(T_RP - 1);
                    end
                    PH_PRE: begin
                        if (left_q == '0) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            phase_q <= PH_SETUP;
                            cnt_q   <= TW'(T_CSR - 1);
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        strobe_o.ras_n = !((phase_q == PH_HOLD) || (phase_q == PH_LOW));
        strobe_o.cas_n = !((phase_q == PH_SETUP) || (phase_q == PH_HOLD));
    end

    assign busy_o = (phase_q != PH_IDLE);
    assign done_o = done_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import dram_seq_pkg::*;
#(
    parameter int REF_INTERVAL = 1560,
    parameter int DEADLINE_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic take_i,
    input  logic clear_miss_i,
    output logic pending_o,
    output logic missed_o
);
    localparam int IW = cnt_w(REF_INTERVAL);
    localparam int DW = cnt_w(DEADLINE_CYC);
    localparam logic [IW-1:0] RELOAD = IW'(REF_INTERVAL - 1);
    localparam logic [DW-1:0] DLAST  = DW'(DEADLINE_CYC - 1);

    logic [IW-1:0] ictr_q;
    logic [DW-1:0] wait_q;
    logic          pend_q;
    logic          miss_q;
    logic          tick;

    assign tick = en_i && (ictr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ictr_q <= RELOAD;
            wait_q <= '0;
            pend_q <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            if (!en_i || tick) begin
                ictr_q <= RELOAD;
            end else begin
                ictr_q <= ictr_q - 1'b1;
            end

            if (tick) begin
                pend_q <= 1'b1;
            end else if (take_i) begin
                pend_q <= 1'b0;
            end

            if (!pend_q || take_i) begin
                wait_q <= '0;
            end else if (wait_q != DLAST) begin
                wait_q <= wait_q + 1'b1;
            end

            if (clear_miss_i) begin
                miss_q <= 1'b0;
            end else if (pend_q && !take_i && (wait_q == DLAST)) begin
                miss_q <= 1'b1;
            end
        end
    end

    assign pending_o = pend_q;
    assign missed_o  = miss_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_seq_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int WAKE_CNT     = 8,
    parameter int REF_INTERVAL = 1560,
    parameter int DEADLINE_CYC = 1560,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 1,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt_i,
    output logic ref_req_o,
    output logic bus_own_o,
    output logic mem_ready_o,
    output logic ras_n_o,
    output logic lcas_n_o,
    output logic ucas_n_o
);
    localparam int NW = cnt_w(WAKE_CNT);

    seq_state_t    state_q;
    logic          pause_done;
    logic          eng_start;
    logic [NW-1:0] eng_burst;
    strobe_t       strobe;
    logic          eng_busy;
    logic          eng_done;
    logic          sched_en;
    logic          pending;
    logic          missed;
    logic          take;

    settle_timer #(.CYCLES(PAUSE_CYC)) u_pause (
        .clk       (clk),
        .rst       (rst),
        .expired_o (pause_done)
    );

    assign take      = (state_q == ST_RUN) && pending && ref_gnt_i;
    assign eng_start = ((state_q == ST_PAUSE) && pause_done) || take;
    assign eng_burst = ((state_q == ST_PAUSE) || missed) ? NW'(WAKE_CNT) : NW'(1);
    assign sched_en  = (state_q == ST_RUN) || (state_q == ST_REF);

    cbr_engine #(
        .T_CSR     (T_CSR),
        .T_CHR     (T_CHR),
        .T_RAS     (T_RAS),
        .T_RP      (T_RP),
        .MAX_BURST (WAKE_CNT)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start_i  (eng_start),
        .burst_i  (eng_burst),
        .strobe_o (strobe),
        .busy_o   (eng_busy),
        .done_o   (eng_done)
    );

    refresh_sched #(
        .REF_INTERVAL (REF_INTERVAL),
        .DEADLINE_CYC (DEADLINE_CYC)
    ) u_sched (
        .clk          (clk),
        .rst          (rst),
        .en_i         (sched_en),
        .take_i       (take),
        .clear_miss_i (eng_done),
        .pending_o    (pending),
        .missed_o     (missed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PAUSE;
        end else begin
            case (state_q)
                ST_PAUSE: if (pause_done) state_q <= ST_WAKE;
                ST_WAKE:  if (eng_done)   state_q <= ST_RUN;
                ST_RUN:   if (take)       state_q <= ST_REF;
                ST_REF:   if (eng_done)   state_q <= ST_RUN;
                default:                  state_q <= ST_PAUSE;
            endcase
        end
    end

    assign ref_req_o   = (state_q == ST_RUN) && pending;
    assign bus_own_o   = (state_q != ST_RUN) || eng_busy;
    assign mem_ready_o = sched_en && !missed;
    assign ras_n_o     = strobe.ras_n;
    assign lcas_n_o    = strobe.cas_n;
    assign ucas_n_o    = strobe.cas_n;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
    parameter int T_RAS = 6,
    parameter int T_RP  = 4
) (
    input logic clk,
    input logic rst,
    input logic ras_n_o,
    input logic lcas_n_o,
    input logic ucas_n_o,
    input logic bus_own_o,
    input logic ref_req_o
);
    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || ras_n_o) begin
            lo_cnt <= '0;
        end else if (lo_cnt != 16'hFFFF) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !ras_n_o) begin
            hi_cnt <= '0;
        end else if (lcas_n_o && hi_cnt != 16'hFFFF) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_cas_pair_R10: assert property (@(posedge clk) disable iff (rst)
        lcas_n_o == ucas_n_o);

    assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> (!$past(lcas_n_o) && !lcas_n_o));

    assert_cas_up_under_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lcas_n_o) |-> !ras_n_o);

    assert_ras_min_low_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n_o) |-> (lo_cnt >= 16'(T_RAS)));

    assert_precharge_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> (hi_cnt >= 16'(T_RP)));

    assert_strobe_owned_R8: assert property (@(posedge clk) disable iff (rst)
        (!ras_n_o || !lcas_n_o) |-> bus_own_o);

    assert_req_not_owned_R8: assert property (@(posedge clk) disable iff (rst)
        ref_req_o |-> !bus_own_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n_o   (ras_n_o),
    .lcas_n_o  (lcas_n_o),
    .ucas_n_o  (ucas_n_o),
    .bus_own_o (bus_own_o),
    .ref_req_o (ref_req_o)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
    localparam int P   = 20;
    localparam int W   = 4;
    localparam int I   = 60;
    localparam int D   = 100;
    localparam int CSR = 2;
    localparam int CHR = 2;
    localparam int RAS = 5;
    localparam int RP  = 3;
    localparam int PER = CSR + RAS + RP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic req, own, ready, ras_n, lcas_n, ucas_n;

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(P), .WAKE_CNT(W), .REF_INTERVAL(I), .DEADLINE_CYC(D),
        .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP)
    ) dut (
        .clk(clk), .rst(rst), .ref_gnt_i(gnt), .ref_req_o(req),
        .bus_own_o(own), .mem_ready_o(ready), .ras_n_o(ras_n),
        .lcas_n_o(lcas_n), .ucas_n_o(ucas_n)
    );

    typedef struct { int setup; int hold; int low; } pulse_t;
    pulse_t exp_q[$];

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int first_cas = -1;
    int pulses = 0;
    int own_viol = 0;
    int pair_viol = 0;
    int gap_viol = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
        end
    endtask

    task automatic push_exp(input int n);
        for (int k = 0; k < n; k++) begin
            pulse_t p;
            p.setup = CSR; p.hold = CHR; p.low = RAS;
            exp_q.push_back(p);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cyc = 0; else cyc = cyc + 1;
    end

    // monitor: measures every RAS pulse and scores it against the queue
    initial begin
        int pre = 0, hi = 0, lo = 0, hd = 0, su = 0;
        bit prev_r = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (lcas_n !== ucas_n) pair_viol++;                       // R10
                if ((!ras_n || !lcas_n) && !own) own_viol++;              // R8
                if (req && own) own_viol++;                               // R8
                if (!lcas_n && first_cas < 0) first_cas = cyc;
                if (!ras_n) begin
                    if (prev_r) begin
                        su = pre; lo = 1; hd = (!lcas_n) ? 1 : 0;
                        if (pulses > 0 && hi < RP) gap_viol++;            // R5
                    end else begin
                        lo++; if (!lcas_n) hd++;
                    end
                    pre = 0; hi = 0;
                end else begin
                    if (!prev_r) begin
                        pulses++;
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R7 unexpected RAS pulse", pulses, 0);
                        end else begin
                            pulse_t e;
                            e = exp_q.pop_front();
                            chk(su == e.setup, "R4 CAS setup", su, e.setup);
                            chk(hd == e.hold,  "R4 CAS hold",  hd, e.hold);
                            chk(lo == e.low,   "R4 RAS low",   lo, e.low);
                        end
                    end
                    if (!lcas_n) pre++; else begin pre = 0; hi++; end
                end
                prev_r = ras_n;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic grant_one();
        bit dropped = 1'b0;
        while (!req) @(negedge clk);
        push_exp(1);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        chk(own == 1'b1, "R7 own after grant", own, 1);
        chk(req == 1'b0, "R7 req after grant", req, 0);
        while (own) begin
            if (!ready) dropped = 1'b1;
            @(negedge clk);
        end
        chk(!dropped, "R7 ready held", dropped, 0);
        chk(exp_q.size() == 0, "R7 single pulse", exp_q.size(), 0);
    endtask

    initial begin
        int ready_cyc, req_cyc, pc;
        repeat (3) @(negedge clk);
        // R1
        chk(ras_n == 1'b1,  "R1 ras", ras_n, 1);
        chk(lcas_n == 1'b1 && ucas_n == 1'b1, "R1 cas", lcas_n, 1);
        chk(own == 1'b1,    "R1 own", own, 1);
        chk(ready == 1'b0,  "R1 ready", ready, 0);
        chk(req == 1'b0,    "R1 req", req, 0);
        push_exp(W);
        rst = 1'b0;
        while (!ready) @(negedge clk);
        ready_cyc = cyc;
        chk(first_cas == P, "R2 pause length", first_cas, P);
        chk(ready_cyc == P + W * PER + 1, "R3 ready time", ready_cyc, P + W * PER + 1);
        chk(pulses == W, "R3 wake count", pulses, W);
        chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);

        while (!req) @(negedge clk);
        req_cyc = cyc;
        chk(req_cyc - ready_cyc == I, "R6 first request", req_cyc - ready_cyc, I);

        pc = pulses;
        repeat (15) @(negedge clk);
        chk(req == 1'b1, "R7 req held", req, 1);
        chk(pulses == pc && ras_n && lcas_n, "R7 no strobes ungranted", pulses, pc);
        grant_one();
        for (int k = 0; k < 3; k++) grant_one();

        // R9 deadline miss
        while (!req) @(negedge clk);
        req_cyc = cyc;
        while (ready) @(negedge clk);
        chk(cyc - req_cyc == D, "R9 miss time", cyc - req_cyc, D);
        chk(req == 1'b1 && own == 1'b0, "R9 still requesting", req, 1);
        pc = pulses;
        push_exp(W);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        while (!ready) @(negedge clk);
        chk(pulses - pc == W, "R9 rerun count", pulses - pc, W);
        chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        grant_one();

        chk(own_viol == 0,  "R8 ownership", own_viol, 0);
        chk(pair_viol == 0, "R10 CAS pair", pair_viol, 0);
        chk(gap_viol == 0,  "R5 precharge", gap_viol, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule